// File: doc/BRIEF.md
# Cascadable Modulo Up/Down Counter

This block is a chain of synchronous counting stages. Each stage holds a value that runs cyclically through 0 to MAX_VAL-1, where MAX_VAL is any integer of at least 2 and need not be a power of two. A shared direction input picks incrementing or decrementing. Each stage raises a one-cycle wrap flag when its value rolls past the end of its range. In the up direction that end is MAX_VAL-1 to 0. In the down direction it is 0 to MAX_VAL-1, which acts as a borrow.

The first stage steps on every clock edge on which the count enable is high. Every later stage steps only on the edges where the flag of the stage below it is high. With the default of two stages, the block forms a two-digit counter in base MAX_VAL, and the upper digit lags one cycle behind the wrap of the lower digit. A synchronous parallel load presets all stages at once, each stage from its own slice of the data input. A loaded value outside the range is folded back into it.

The reset input is active low. It clears every stage at once, without waiting for a clock edge. Its release passes through a two-flop synchroniser before the stages leave reset.

Top module: `modcnt_cascade`

## Requirements
- R1: While rst_n is low, every count and every wrap flag reads 0, and they clear as soon as rst_n falls, without waiting for a clock edge.
- R2: After rst_n rises, the first two rising clock edges leave all stages at 0. The third rising edge is the first one that can load or count.
- R3: With count_down=0, a stepping stage goes from v to v+1, and from MAX_VAL-1 to 0. Its value never leaves 0..MAX_VAL-1.
- R4: With count_down=1, a stepping stage goes from v to v-1, and from 0 to MAX_VAL-1.
- R5: A stage's wrap flag is high for exactly the one cycle after an edge on which that stage wrapped, in either direction, and is low in all other cycles.
- R6: load_en=1 at an edge sets stage k to its slice par_din[k*W +: W], where W = clog2(MAX_VAL) with a minimum of 1. This takes priority over counting and clears every wrap flag.
- R7: A loaded slice value of MAX_VAL or more is stored as that value modulo MAX_VAL. With MAX_VAL=10, a value of 12 is stored as 2 and a value of 15 as 5.
- R8: With cnt_en=0 and load_en=0, stage 0 holds its value and its wrap flag stays low.
- R9: Stage k>0 steps, in the current direction, exactly on those edges where the wrap flag of stage k-1 is high.
- R10: Reset takes priority over load. A load request while rst_n is low changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset; asserts without a clock edge, release is synchronised |
| load_en | input | 1 | Synchronous parallel load of all stages |
| count_down | input | 1 | 0 = increment, 1 = decrement |
| cnt_en | input | 1 | Step enable for stage 0 |
| par_din | input | STAGES*W | Load data; stage k uses bits [k*W +: W] |
| count_out | output | STAGES*W | Stage values; stage k on bits [k*W +: W] |
| wrap_out | output | STAGES | Registered one-cycle wrap flag per stage |

## Verification
Long runs with a steady enable, first upward and then downward, take both digits through several full cycles. These runs separate a correct modulus and correct wrap edges from an off-by-one at either end of the range. They also show whether the upper digit follows the lower digit's flag with the right one-cycle lag. A gapped enable pattern tells real holding apart from free-running counting. Loads of in-range, out-of-range and all-top values tell the folding logic, the load-over-count priority and the flag clearing apart from one another. A load asserted together with reset, followed by a release, shows that reset has priority and that the release latency is correct.

// File: rtl/modcnt_pkg.sv
package modcnt_pkg;

  typedef enum logic {
    DIR_UP   = 1'b0,
    DIR_DOWN = 1'b1
  } modcnt_dir_e;

  // Width needed to hold 0..m-1, never less than one bit.
  function automatic int unsigned cnt_width(input int unsigned m);
    return (m <= 2) ? 1 : $clog2(m);
  endfunction

  function automatic bit is_pow2(input int unsigned m);
    return (m != 0) && ((m & (m - 1)) == 0);
  endfunction

endpackage

// File: rtl/modcnt_rst_sync.sv
module modcnt_rst_sync #(
  parameter int unsigned DEPTH = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [DEPTH-1:0] sync_q;
  logic [DEPTH-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[DEPTH-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[DEPTH-1];
endmodule

// File: rtl/modcnt_fold.sv
module modcnt_fold #(
  parameter int unsigned MAX_VAL = 10,
  parameter int unsigned W       = 4
) (
  input  logic [W-1:0] raw_i,
  output logic [W-1:0] fold_o
);
  import modcnt_pkg::*;

  generate
    if (is_pow2(MAX_VAL) && (MAX_VAL == (1 << W))) begin : g_pass
      // Every W-bit code is already in range.
      assign fold_o = raw_i;
    end else begin : g_sub
      // Minimal W guarantees raw_i < 2*MAX_VAL, so a single subtract folds it.
      localparam logic [W-1:0] MODV = W'(MAX_VAL);
      assign fold_o = (raw_i >= MODV) ? (raw_i - MODV) : raw_i;
    end
  endgenerate
endmodule

// File: rtl/modcnt_stage.sv
module modcnt_stage #(
  parameter int unsigned MAX_VAL = 10,
  parameter int unsigned W       = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic         down_i,
  input  logic         step_i,
  input  logic [W-1:0] din_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);
  import modcnt_pkg::*;

  localparam logic [W-1:0] LAST = W'(MAX_VAL - 1);

  logic [W-1:0] cnt_q, cnt_d, din_fold;
  logic         wrap_q, wrap_d;
  logic         cnt_ce;
  modcnt_dir_e  dir;

  modcnt_fold #(.MAX_VAL(MAX_VAL), .W(W)) u_fold (
    .raw_i  (din_i),
    .fold_o (din_fold)
  );

  assign dir    = modcnt_dir_e'(down_i);
  assign cnt_ce = load_i | step_i;

  always_comb begin
    cnt_d  = cnt_q;
    wrap_d = 1'b0;
    if (load_i) begin
      cnt_d = din_fold;
    end else if (step_i) begin
      if (dir == DIR_DOWN) begin
        if (cnt_q == '0) begin
          cnt_d  = LAST;
          wrap_d = 1'b1;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end else begin
        if (cnt_q == LAST) begin
          cnt_d  = '0;
          wrap_d = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_ce) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wrap_q <= 1'b0;
    else        wrap_q <= wrap_d;
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = wrap_q;
endmodule

// File: rtl/modcnt_cascade.sv
module modcnt_cascade #(
  parameter int unsigned MAX_VAL = 10,
  parameter int unsigned STAGES  = 2,
  parameter int unsigned SYNC_DEPTH = 2
) (
  input  logic                                              clk,
  input  logic                                              rst_n,
  input  logic                                              load_en,
  input  logic                                              count_down,
  input  logic                                              cnt_en,
  input  logic [STAGES*modcnt_pkg::cnt_width(MAX_VAL)-1:0]  par_din,
  output logic [STAGES*modcnt_pkg::cnt_width(MAX_VAL)-1:0]  count_out,
  output logic [STAGES-1:0]                                 wrap_out
);
  import modcnt_pkg::*;

  localparam int unsigned W = cnt_width(MAX_VAL);

  logic            rst_core_n;
  logic [STAGES:0] step_chain;

  modcnt_rst_sync #(.DEPTH(SYNC_DEPTH)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  assign step_chain[0] = cnt_en;

  generate
    for (genvar k = 0; k < STAGES; k++) begin : g_stage
      modcnt_stage #(.MAX_VAL(MAX_VAL), .W(W)) u_stage (
        .clk    (clk),
        .rst_n  (rst_core_n),
        .load_i (load_en),
        .down_i (count_down),
        .step_i (step_chain[k]),
        .din_i  (par_din[k*W +: W]),
        .cnt_o  (count_out[k*W +: W]),
        .wrap_o (step_chain[k+1])
      );
    end
  endgenerate

  assign wrap_out = step_chain[STAGES:1];
endmodule

// File: rtl/modcnt_chk.sv
module modcnt_chk #(
  parameter int unsigned MAX_VAL = 10,
  parameter int unsigned STAGES  = 2
) (
  input logic                                             clk,
  input logic                                             rst_n,
  input logic                                             load_en,
  input logic                                             count_down,
  input logic                                             cnt_en,
  input logic [STAGES*modcnt_pkg::cnt_width(MAX_VAL)-1:0] count_out,
  input logic [STAGES-1:0]                                wrap_out
);
  import modcnt_pkg::*;

  localparam int unsigned W = cnt_width(MAX_VAL);
  localparam logic [W-1:0] LAST = W'(MAX_VAL - 1);

  // R6: a load leaves every wrap flag low
  a_r6_load_clears_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> (wrap_out == '0));

  // R8: stage 0 holds without enable or load
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_en && !load_en) |=> $stable(count_out[W-1:0]));

  generate
    for (genvar k = 0; k < STAGES; k++) begin : g_chk
      // R3: value stays inside the modulus
      a_r3_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        count_out[k*W +: W] <= LAST);

      // R5: flag lasts one cycle
      a_r5_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_out[k] |=> !wrap_out[k]);

      // R4: flag coincides with the value just past the wrap point
      a_r4_wrap_value: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_out[k] |-> (count_out[k*W +: W] == ($past(count_down) ? LAST : '0)));

      if (k > 0) begin : g_casc
        // R9: upper stage moves only on the lower flag
        a_r9_cascade_hold: assert property (@(posedge clk) disable iff (!rst_n)
          (!wrap_out[k-1] && !load_en) |=> $stable(count_out[k*W +: W]));
      end
    end
  endgenerate
endmodule

bind modcnt_cascade modcnt_chk #(.MAX_VAL(MAX_VAL), .STAGES(STAGES)) u_modcnt_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .load_en    (load_en),
  .count_down (count_down),
  .cnt_en     (cnt_en),
  .count_out  (count_out),
  .wrap_out   (wrap_out)
);

// File: tb/tb_modcnt_cascade.sv
`timescale 1ns/1ps
module tb_modcnt_cascade;
  localparam int MAXV = 10;
  localparam int NS   = 2;
  localparam int W    = 4;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic              rst_n = 1'b0;
  logic              load_en = 1'b0;
  logic              count_down = 1'b0;
  logic              cnt_en = 1'b0;
  logic [NS*W-1:0]   par_din = '0;
  logic [NS*W-1:0]   count_out;
  logic [NS-1:0]     wrap_out;

  modcnt_cascade #(.MAX_VAL(MAXV), .STAGES(NS)) dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_en    (load_en),
    .count_down (count_down),
    .cnt_en     (cnt_en),
    .par_din    (par_din),
    .count_out  (count_out),
    .wrap_out   (wrap_out)
  );

  int    errs = 0;
  int    checks = 0;
  string tag = "R1";
  bit    cmp_on = 1'b0;

  // Behavioural reference
  int m_cnt [NS];
  bit m_ovr [NS];
  bit old_ovr [NS];
  int rel = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      rel = 0;
      for (int k = 0; k < NS; k++) begin m_cnt[k] = 0; m_ovr[k] = 0; end
    end else begin
      if (rel >= 2) begin
        for (int k = 0; k < NS; k++) old_ovr[k] = m_ovr[k];
        for (int k = 0; k < NS; k++) begin
          bit en;
          en = (k == 0) ? cnt_en : old_ovr[k-1];
          m_ovr[k] = 0;
          if (load_en) begin
            m_cnt[k] = int'(par_din[k*W +: W]) % MAXV;
          end else if (en) begin
            if (count_down) begin
              if (m_cnt[k] == 0) begin m_cnt[k] = MAXV - 1; m_ovr[k] = 1; end
              else m_cnt[k] = m_cnt[k] - 1;
            end else begin
              if (m_cnt[k] == MAXV - 1) begin m_cnt[k] = 0; m_ovr[k] = 1; end
              else m_cnt[k] = m_cnt[k] + 1;
            end
          end
        end
      end
      if (rel < 2) rel = rel + 1;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on) begin
      for (int k = 0; k < NS; k++) begin
        chk(tag, $sformatf("count[%0d]", k), int'(count_out[k*W +: W]), m_cnt[k]);
        chk(tag, $sformatf("wrap[%0d]", k), int'(wrap_out[k]), int'(m_ovr[k]));
      end
    end
  end

  function automatic int cnt_of(input int k);
    return int'(count_out[k*W +: W]);
  endfunction

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errs, checks);
  endtask

  initial begin
    #1000000;
    checks++;
    errs++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    // R1: held in reset
    cycles(3);
    chk("R1", "count in reset", int'(count_out), 0);
    chk("R1", "wrap in reset", int'(wrap_out), 0);

    // R2: release latency
    cmp_on = 1'b1;
    tag = "R2";
    #1 cnt_en = 1'b1; rst_n = 1'b1;
    @(negedge clk); chk("R2", "count0 after edge 1", cnt_of(0), 0);
    @(negedge clk); chk("R2", "count0 after edge 2", cnt_of(0), 0);
    @(negedge clk); chk("R2", "count0 after edge 3", cnt_of(0), 1);

    // R3 / R9 / R5: long upward run
    tag = "R3";
    cycles(130);

    // R4: long downward run
    tag = "R4";
    #1 count_down = 1'b1;
    cycles(130);

    // R8: gapped enable
    tag = "R8";
    for (int i = 0; i < 60; i++) begin
      #1 cnt_en = ((i % 3) != 0);
      count_down = (i >= 30);
      @(negedge clk);
    end
    #1 cnt_en = 1'b0; load_en = 1'b0;
    @(negedge clk);
    begin
      int h0;
      h0 = cnt_of(0);
      cycles(3);
      chk("R8", "stage0 held", cnt_of(0), h0);
    end

    // R6: load with counting enabled
    tag = "R6";
    #1 cnt_en = 1'b1; count_down = 1'b0; load_en = 1'b1; par_din = {4'd7, 4'd3};
    @(negedge clk);
    chk("R6", "load stage0", cnt_of(0), 3);
    chk("R6", "load stage1", cnt_of(1), 7);
    chk("R6", "wrap after load", int'(wrap_out), 0);

    // R7: out-of-range load folds
    tag = "R7";
    #1 par_din = {4'd15, 4'd12};
    @(negedge clk);
    chk("R7", "fold 12", cnt_of(0), 2);
    chk("R7", "fold 15", cnt_of(1), 5);

    // R5 / R9: both digits at top, then step up
    tag = "R9";
    #1 par_din = {4'd9, 4'd9};
    @(negedge clk);
    #1 load_en = 1'b0;
    @(negedge clk);
    chk("R5", "stage0 wrapped", cnt_of(0), 0);
    chk("R5", "wrap0 high", int'(wrap_out[0]), 1);
    chk("R9", "stage1 not yet", cnt_of(1), 9);
    @(negedge clk);
    chk("R9", "stage1 wrapped", cnt_of(1), 0);
    chk("R5", "wrap1 high", int'(wrap_out[1]), 1);
    chk("R5", "wrap0 dropped", int'(wrap_out[0]), 0);
    @(negedge clk);
    chk("R5", "wrap1 dropped", int'(wrap_out[1]), 0);
    cycles(40);

    // R4 borrow at zero for both digits
    tag = "R4";
    #1 load_en = 1'b1; par_din = {4'd0, 4'd0}; count_down = 1'b1;
    @(negedge clk);
    #1 load_en = 1'b0;
    @(negedge clk);
    chk("R4", "stage0 borrow", cnt_of(0), 9);
    @(negedge clk);
    chk("R4", "stage1 borrow", cnt_of(1), 9);
    chk("R4", "wrap1 borrow", int'(wrap_out[1]), 1);
    cycles(20);

    // R10 / R1: reset with a load request
    tag = "R10";
    #1 rst_n = 1'b0; load_en = 1'b1; par_din = {4'd6, 4'd4};
    #0.5;
    chk("R1", "async clear", int'(count_out), 0);
    @(negedge clk);
    chk("R10", "load ignored in reset", int'(count_out), 0);
    cycles(2);
    #1 rst_n = 1'b1; load_en = 1'b0; count_down = 1'b0;
    tag = "R2";
    cycles(30);

    cmp_on = 1'b0;
    summary();
    $finish;
  end
endmodule